// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for 64 or 96 pins; the pin count is a parameter. The pins are split into banks of 32. Each control function lives in its own register group. A group holds one 32-bit word per bank, so software touches a whole function across a bank with one access.

Software sets a pin's direction and drives its output latch only through write-one set and write-one clear strobes. This means no read-modify-write is needed to change a single pin. Software can also read the synchronized pin levels and choose a 2-bit alternate-function code for each pin; the code is exposed on a port for the pad multiplexer. Rising and falling edge detection is enabled per pin. Detected edges are held in a sticky status register, and software clears its bits by writing ones. A single interrupt line is raised while any status bit is pending.

The bus is a plain 32-bit register port with an active-high write strobe. Read data is combinational from the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register holds zero: pin_out, pin_oe and alt_sel are all zero, irq is low, and every mapped word reads back zero while the pins are held low.
- R2: With NREG = NPINS/32, word w of group g sits at byte address (g*NREG + w)*4, and bus_addr[1:0] is ignored. The group indices are: level 0, direction 1, set 2, clear 3, rise-enable 4, fall-enable 5, edge-status 6, alt-function 7. Within a 1-bit group, pin p maps to word p/32, bit p%32.
- R3: A direction word is written and read back directly. A direction bit of 1 drives pin_oe high for that pin, which makes it an output; 0 makes it an input.
- R4: Writing a 1 into a set-group bit drives that pin's output latch (pin_out) high on the next clock, and zero bits leave the latch unchanged. The set and clear groups read as zero.
- R5: Writing a 1 into a clear-group bit drives that pin's output latch low on the next clock, and zero bits leave the latch unchanged.
- R6: The level group returns the pin inputs after a two-flop synchronizer. A change on pin_in first appears two clock edges later, and it has not yet appeared one edge later.
- R7: With a pin's rise-enable bit set, a low-to-high change on the synchronized input sets that pin's edge-status bit. The bit is readable three clock edges after the pin changes. Without the enable, a rising change leaves status untouched.
- R8: With a pin's fall-enable bit set, a high-to-low change sets its edge-status bit. A rising change on a pin with only fall-enable leaves status untouched. With both enables set, either direction sets the bit.
- R9: Writing ones into the edge-status group clears those bits. Zero bits leave pending status unchanged, and writing all ones clears every pending bit of that word.
- R10: If a new enabled edge is detected in the same clock as a clear write to that status bit, the bit stays set.
- R11: irq is high exactly when at least one edge-status bit is set. It rises only after an input change and falls only after a bus write.
- R12: The alt-function group holds 2*NREG words starting at byte address 7*NREG*4. Pin p's 2-bit code is in word p/16 at bits (p%16)*2+1:(p%16)*2, and it appears on alt_sel[2p+1:2p].
- R13: Reads above the last alt-function word return zero. Writes to the level group have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Output latch per pin |
| pin_oe | output | NPINS | Output enable per pin (direction bit) |
| alt_sel | output | 2*NPINS | Alternate-function code, two bits per pin |
| irq | output | 1 | High while any edge-status bit is pending |

## Verification
The assertions check the following on every cycle:
- a set or clear strobe moves pin_out on the next edge, and a direction or alt-function write lands on its port;
- irq never rises unless pin_in changed at the point that matches the synchronizer and detector latency, and never falls without a bus write;
- unmapped reads return zero.

Only the bench scenarios can show the behaviours that depend on exact history:
- the edge-enable combinations and W1C masking;
- the race between a new edge and a clear in the same cycle;
- the two-cycle level latency;
- the full address map across all three banks under random register traffic.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPINS  = 96,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic [2*NPINS-1:0]   alt_sel,
  output logic                 irq
);
  localparam int NREG  = NPINS / 32;
  localparam int NALT  = 2 * NREG;
  localparam int WIX_W = ADDR_W - 2;
  localparam int G_LVL = 0, G_DIR = 1, G_SET = 2, G_CLR = 3;
  localparam int G_REN = 4, G_FEN = 5, G_STS = 6, G_ALT = 7;

  logic [WIX_W-1:0]   widx;
  logic [NPINS-1:0]   sync_a, sync_b, sync_h;
  logic [NPINS-1:0]   dir_q, out_q, ren_q, fen_q, sts_q;
  logic [2*NPINS-1:0] alt_q;
  logic [NPINS-1:0]   hit, w1c;

  assign widx = bus_addr[ADDR_W-1:2];

  function automatic logic sel(input logic [WIX_W-1:0] ix, input int g, input int w);
    return ix == WIX_W'(g * NREG + w);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_h <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      sync_h <= sync_b;
    end
  end

  assign hit = (sync_b & ~sync_h & ren_q) | (~sync_b & sync_h & fen_q);

  always_comb begin
    w1c = '0;
    for (int w = 0; w < NREG; w++)
      if (bus_wr && sel(widx, G_STS, w)) w1c[w*32 +: 32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      sts_q <= '0;
      alt_q <= '0;
    end else begin
      for (int w = 0; w < NREG; w++) begin
        if (bus_wr && sel(widx, G_DIR, w)) dir_q[w*32 +: 32] <= bus_wdata;
        if (bus_wr && sel(widx, G_SET, w)) out_q[w*32 +: 32] <= out_q[w*32 +: 32] | bus_wdata;
        if (bus_wr && sel(widx, G_CLR, w)) out_q[w*32 +: 32] <= out_q[w*32 +: 32] & ~bus_wdata;
        if (bus_wr && sel(widx, G_REN, w)) ren_q[w*32 +: 32] <= bus_wdata;
        if (bus_wr && sel(widx, G_FEN, w)) fen_q[w*32 +: 32] <= bus_wdata;
      end
      for (int w = 0; w < NALT; w++)
        if (bus_wr && sel(widx, G_ALT, w)) alt_q[w*32 +: 32] <= bus_wdata;
      sts_q <= (sts_q & ~w1c) | hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NREG; w++) begin
      if (sel(widx, G_LVL, w)) bus_rdata = sync_b[w*32 +: 32];
      if (sel(widx, G_DIR, w)) bus_rdata = dir_q[w*32 +: 32];
      if (sel(widx, G_REN, w)) bus_rdata = ren_q[w*32 +: 32];
      if (sel(widx, G_FEN, w)) bus_rdata = fen_q[w*32 +: 32];
      if (sel(widx, G_STS, w)) bus_rdata = sts_q[w*32 +: 32];
    end
    for (int w = 0; w < NALT; w++)
      if (sel(widx, G_ALT, w)) bus_rdata = alt_q[w*32 +: 32];
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign alt_sel = alt_q;
  assign irq     = |sts_q;
endmodule

module gpio_bank_ctrl_chk #(
  parameter int NPINS  = 96,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NPINS-1:0]     pin_in,
  input logic [NPINS-1:0]     pin_out,
  input logic [NPINS-1:0]     pin_oe,
  input logic [2*NPINS-1:0]   alt_sel,
  input logic                 irq
);
  localparam int NREG  = NPINS / 32;
  localparam int WIX_W = ADDR_W - 2;
  logic [WIX_W-1:0] ix;
  assign ix = bus_addr[ADDR_W-1:2];

  assert_set_drives_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && ix == WIX_W'(2*NREG) && bus_wdata[0] |=> pin_out[0]);

  assert_clr_drives_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && ix == WIX_W'(3*NREG) && bus_wdata[0] |=> !pin_out[0]);

  assert_dir_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && ix == WIX_W'(NREG) |=> pin_oe[31:0] == $past(bus_wdata));

  assert_alt_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && ix == WIX_W'(7*NREG) |=> alt_sel[31:0] == $past(bus_wdata));

  assert_irq_rise_needs_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pin_in, 3) != $past(pin_in, 4));

  assert_irq_fall_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ix >= WIX_W'(9*NREG) |-> bus_rdata == 32'd0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  localparam int NPINS = 96;
  localparam int NREG  = NPINS / 32;

  logic               clk = 0;
  logic               rst_n = 0;
  logic               bus_wr = 0;
  logic [7:0]         bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic [NPINS-1:0]   pin_in = '0;
  logic [NPINS-1:0]   pin_out, pin_oe;
  logic [2*NPINS-1:0] alt_sel;
  logic               irq;

  int n_chk = 0, n_bad = 0;
  logic done = 0;

  gpio_bank_ctrl #(.NPINS(NPINS), .ADDR_W(8)) uut (.*);

  always #10 clk = ~clk;

  logic [NPINS-1:0]   m_dir = '0, m_out = '0;
  logic [2*NPINS-1:0] m_alt = '0;

  function automatic int A(int g, int w);
    return (g * NREG + w) * 4;
  endfunction

  task automatic chk(string req, logic [191:0] act, logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_wr = 1; bus_addr = a[7:0]; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = a[7:0]; #1; d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    cyc(4);
    rst_n = 1;
    cyc(1);

    // R1: reset state
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 alt_sel", alt_sel, '0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 9 * NREG; a++) begin
      rd(a * 4, d);
      chk("R1 readback", d, 0);
    end

    // R13: unmapped and level-group write
    rd(9 * NREG * 4, d);  chk("R13 unmapped first", d, 0);
    rd(8'hFC, d);         chk("R13 unmapped top", d, 0);
    wr(A(0, 1), 32'hFFFF_FFFF);
    rd(A(0, 1), d);       chk("R13 level write ignored", d, 0);

    // R6: level latency
    pin_in = {32'hA5A5_0F0F, 32'h1234_5678, 32'hDEAD_BEEF};
    cyc(1);
    rd(A(0, 0), d);  chk("R6 level not yet", d, 0);
    cyc(1);
    for (int w = 0; w < NREG; w++) begin
      rd(A(0, w) | 3, d);
      chk("R6 R2 level word", d, pin_in[w*32 +: 32]);
    end
    pin_in = '0;
    cyc(3);

    // R3 R4 R5 R12 R2: random traffic
    for (int it = 0; it < 300; it++) begin
      int pick = $urandom % 6;
      int g = (pick == 5) ? 7 : pick + 1;
      int w = (g == 7) ? $urandom % (2 * NREG) : $urandom % NREG;
      logic [31:0] v = $urandom;
      wr(A(g, w) | ($urandom % 4), v);
      case (g)
        1: m_dir[w*32 +: 32] = v;
        2: m_out[w*32 +: 32] = m_out[w*32 +: 32] | v;
        3: m_out[w*32 +: 32] = m_out[w*32 +: 32] & ~v;
        7: m_alt[w*32 +: 32] = v;
        default: ;
      endcase
      rd(A(g, w), d);
      case (g)
        1: begin chk("R3 dir readback", d, v); chk("R3 pin_oe", pin_oe, m_dir); end
        2: begin chk("R4 set reads zero", d, 0); chk("R4 pin_out", pin_out, m_out); end
        3: begin chk("R5 clr reads zero", d, 0); chk("R5 pin_out", pin_out, m_out); end
        7: begin
             int p = $urandom % NPINS;
             logic [31:0] aw = m_alt[(p/16)*32 +: 32];
             chk("R12 alt readback", d, v);
             chk("R12 alt_sel", alt_sel, m_alt);
             chk("R12 pin field", alt_sel[2*p +: 2], aw[(p%16)*2 +: 2]);
           end
        default: chk("R2 enable readback", d, v);
      endcase
    end
    for (int w = 0; w < NREG; w++) begin
      wr(A(4, w), 0); wr(A(5, w), 0);
    end
    chk("R11 no irq after traffic", irq, 0);

    // R7: rise on pin 40 enabled, pin 5 not
    wr(A(4, 1), 32'h100);
    pin_in[40] = 1; pin_in[5] = 1;
    cyc(2);
    rd(A(6, 1), d);  chk("R7 status not yet", d, 0);
    cyc(1);
    rd(A(6, 1), d);  chk("R7 rise sets", d, 32'h100);
    rd(A(6, 0), d);  chk("R7 disabled rise", d, 0);
    chk("R11 irq high", irq, 1);

    // R8: fall on pin 95 only
    wr(A(5, 2), 32'h8000_0000);
    pin_in[95] = 1;
    cyc(3);
    rd(A(6, 2), d);  chk("R8 rise ignored with fall-only", d, 0);
    pin_in[95] = 0;
    cyc(3);
    rd(A(6, 2), d);  chk("R8 fall sets", d, 32'h8000_0000);

    // R9: W1C behaviour
    wr(A(6, 2), 32'h7FFF_FFFF);
    rd(A(6, 2), d);  chk("R9 zero bits keep", d, 32'h8000_0000);
    wr(A(6, 2), 32'hFFFF_FFFF);
    rd(A(6, 2), d);  chk("R9 all ones clear", d, 0);

    // R8: both enables on pin 5 (currently high)
    wr(A(4, 0), 32'h20); wr(A(5, 0), 32'h20);
    pin_in[5] = 0;
    cyc(3);
    rd(A(6, 0), d);  chk("R8 both: fall", d, 32'h20);
    wr(A(6, 0), 32'h20);
    rd(A(6, 0), d);  chk("R9 clear pin5", d, 0);
    pin_in[5] = 1;
    cyc(3);
    rd(A(6, 0), d);  chk("R8 both: rise", d, 32'h20);
    wr(A(6, 0), 32'h20);

    // R10: new edge and clear in the same cycle, pin 40 still pending
    rd(A(6, 1), d);  chk("R10 precondition", d, 32'h100);
    pin_in[40] = 0;
    cyc(3);
    pin_in[40] = 1;
    cyc(2);
    wr(A(6, 1), 32'h100);
    rd(A(6, 1), d);  chk("R10 edge wins", d, 32'h100);
    chk("R11 irq held", irq, 1);
    wr(A(6, 1), 32'h100);
    rd(A(6, 1), d);  chk("R9 plain clear", d, 0);
    cyc(1);
    chk("R11 irq low", irq, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule